// File: doc/BRIEF.md
# Indexed Event Interrupt Controller

This block collects 64 interrupt events for a chip-to-chip link and turns each into one of two actions. The low 32 events come from chip-level level sources. The upper 32 come from queue status flags that are high while a queue holds entries. Every event has its own configuration word: enable, software-trigger enable, secure-only flag, polarity, a type bit, a 3-bit MPS field and a vector. Software reaches a word by writing the event number to an index register and then reading or writing a value register. The value register is at byte offset 0x04.

A global mode bit picks what a detected event does. In local mode, the event sets the pending bit selected by its vector. In remote mode, the event queues a packet request carrying its event number, MPS and vector. The request goes out on a valid/ready handshake, lowest event number first. Software can also raise an event through a trigger register, subject to its enable bits and its secure-only flag. Pending bits are cleared by writing a vector number to a clear register.

Top module: `evt_irq_ctl`

## Requirements
- R1: After reset, every configuration word, the index, the mode bit (0 = remote) and all pending bits are zero, and `pkt_valid` is low.
- R2: Register map, as byte addresses on `reg_addr`:
  - 0x00 index (event number, reads back).
  - 0x04 value word of the indexed event.
  - 0x08 software trigger (write the event number).
  - 0x0C pending clear (write the vector number).
  - 0x10 pending bits (read).
  - 0x14 mode (bit 0, 1 = local).
  
  Writing the value word changes only the indexed event.
- R3: Value word layout:
  - bits 4:0 vector
  - bits 10:8 MPS
  - bit 16 type
  - bit 17 polarity
  - bit 18 secure-only
  - bit 19 software enable
  - bit 20 enable
  
  Type always reads 0, since only level type is supported. Bits 15:11 read 0, because only 3 MPS bits are kept.
- R4: A chip event (0–31) with enable set is raised when its input becomes active: high for polarity 0, low for polarity 1. A disabled event is never raised.
- R5: A queue event (32–63) with polarity 0 is raised when its queue becomes non-empty. With polarity 1 it is raised when its queue becomes empty.
- R6: In local mode, a raised event sets `irq_pend[vector]` on the clock edge that detects it, and no packet is requested.
- R7: In remote mode, a raised event drives `pkt_valid` with its event number, MPS and vector, and leaves the pending bits alone. A presented request holds its fields until `pkt_ready` is high at a clock edge.
- R8: When several requests wait and none is presented, the lowest event number is presented first.
- R9: A software-trigger write raises the named event on that edge only when both enable and software enable are set. Otherwise it is ignored.
- R10: An event with secure-only set ignores software-trigger writes made with `reg_secure` low, and accepts them with `reg_secure` high.
- R11: Writing vector v to the clear register clears `irq_pend[v]` on that edge, unless the same edge also sets it.
- R12: Switching to local mode turns every waiting packet request into its pending bit on the following edge, and drops `pkt_valid` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_secure | input | 1 | Access comes from a secure master |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| chip_evt | input | 32 | Chip-level event levels, events 0–31 |
| q_nonempty | input | 32 | Queue non-empty flags, events 32–63 |
| pkt_valid | output | 1 | Packet request valid |
| pkt_ready | input | 1 | Packet request accepted |
| pkt_evt | output | 6 | Event number of the presented request |
| pkt_mps | output | 3 | MPS of the presented request |
| pkt_vec | output | 5 | Vector of the presented request |
| irq_pend | output | 32 | Local pending bits, indexed by vector |

## Verification
The bench programs inverted polarity while the input is already at its active level, so the act of enabling creates the edge. A design that compared raw levels instead would fire early or stay silent. It raises two requests on one cycle and another request under a held one. Wrong arbitration would show up as a request presented out of order or a presented request being swapped. It drives software triggers with each enable bit missing and with a non-secure master, where a loose qualifier would set a pending bit. It also flips the mode while a request waits. A design that dropped queued requests on the mode change would lose that pending bit.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   localparam int unsigned DATA_W    = 32;
   localparam int unsigned ADDR_W    = 5;
   localparam int unsigned MPS_W     = 3;
   // value word field positions
   localparam int unsigned F_VEC_LSB = 0;
   localparam int unsigned F_MPS_LSB = 8;
   localparam int unsigned F_TYPE    = 16;
   localparam int unsigned F_POL     = 17;
   localparam int unsigned F_SEC     = 18;
   localparam int unsigned F_SWEN    = 19;
   localparam int unsigned F_EN      = 20;

   typedef enum logic [2:0] {
      RS_IDX  = 3'd0,
      RS_VAL  = 3'd1,
      RS_SWI  = 3'd2,
      RS_CLR  = 3'd3,
      RS_PEND = 3'd4,
      RS_MODE = 3'd5
   } reg_sel_e;
endpackage

// File: rtl/evt_cfg_bank.sv
module evt_cfg_bank
   import evt_irq_pkg::*;
#(
   parameter int unsigned NUM_EVT = 64,
   parameter int unsigned VEC_W   = 5,
   localparam int unsigned IDX_W  = $clog2(NUM_EVT)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_idx,
   input  logic                           wr_val,
   input  logic [DATA_W-1:0]              wdata,
   output logic [IDX_W-1:0]               idx,
   output logic [DATA_W-1:0]              val_word,
   output logic [NUM_EVT-1:0]             en,
   output logic [NUM_EVT-1:0]             swen,
   output logic [NUM_EVT-1:0]             pol,
   output logic [NUM_EVT-1:0]             sec,
   output logic [NUM_EVT-1:0][MPS_W-1:0]  mps,
   output logic [NUM_EVT-1:0][VEC_W-1:0]  vec
);
   if (VEC_W + F_VEC_LSB > F_MPS_LSB) begin : g_chk_vec
      $error("VEC_W overlaps the MPS field");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx <= '0;
      else if (wr_idx) idx <= wdata[IDX_W-1:0];
   end

   for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en[e]   <= 1'b0;
            swen[e] <= 1'b0;
            pol[e]  <= 1'b0;
            sec[e]  <= 1'b0;
            mps[e]  <= '0;
            vec[e]  <= '0;
         end else if (wr_val && idx == IDX_W'(e)) begin
            en[e]   <= wdata[F_EN];
            swen[e] <= wdata[F_SWEN];
            pol[e]  <= wdata[F_POL];
            sec[e]  <= wdata[F_SEC];
            mps[e]  <= wdata[F_MPS_LSB +: MPS_W];
            vec[e]  <= wdata[F_VEC_LSB +: VEC_W];
         end
      end
   end

   // type is level-only and is never stored; it reads as zero
   always_comb begin
      val_word                        = '0;
      val_word[F_EN]                  = en[idx];
      val_word[F_SWEN]                = swen[idx];
      val_word[F_POL]                 = pol[idx];
      val_word[F_SEC]                 = sec[idx];
      val_word[F_MPS_LSB +: MPS_W]    = mps[idx];
      val_word[F_VEC_LSB +: VEC_W]    = vec[idx];
   end
endmodule

// File: rtl/evt_detect.sv
module evt_detect #(
   parameter int unsigned NUM_EVT = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] lvl_in,
   input  logic [NUM_EVT-1:0] en,
   input  logic [NUM_EVT-1:0] pol,
   input  logic [NUM_EVT-1:0] sw_hit,
   output logic [NUM_EVT-1:0] raise
);
   logic [NUM_EVT-1:0] act, act_q;

   assign act   = en & (lvl_in ^ pol);
   assign raise = (act & ~act_q) | sw_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= '0;
      else        act_q <= act;
   end
endmodule

// File: rtl/evt_pkt_arb.sv
module evt_pkt_arb #(
   parameter int unsigned NUM_EVT = 64,
   localparam int unsigned IDX_W  = $clog2(NUM_EVT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               remote,
   input  logic [NUM_EVT-1:0] raise,
   input  logic               ready,
   output logic               valid,
   output logic [IDX_W-1:0]   sel,
   output logic [NUM_EVT-1:0] drain
);
   logic [NUM_EVT-1:0] flags_q;
   logic               lock_q;
   logic [IDX_W-1:0]   lock_idx_q;
   logic [IDX_W-1:0]   low_idx;
   logic [NUM_EVT-1:0] done;

   always_comb begin
      low_idx = '0;
      for (int i = NUM_EVT - 1; i >= 0; i--) begin
         if (flags_q[i]) low_idx = IDX_W'(i);
      end
   end

   assign valid = remote & (lock_q | (|flags_q));
   assign sel   = lock_q ? lock_idx_q : low_idx;
   assign done  = (valid & ready) ? (NUM_EVT'(1) << sel) : '0;
   assign drain = remote ? '0 : flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q    <= '0;
         lock_q     <= 1'b0;
         lock_idx_q <= '0;
      end else if (!remote) begin
         flags_q    <= '0;
         lock_q     <= 1'b0;
      end else begin
         flags_q    <= (flags_q & ~done) | raise;
         lock_q     <= valid & ~ready;
         lock_idx_q <= sel;
      end
   end
endmodule

// File: rtl/evt_pend.sv
module evt_pend #(
   parameter int unsigned NUM_EVT = 64,
   parameter int unsigned VEC_W   = 5,
   localparam int unsigned NUM_PEND = 1 << VEC_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_EVT-1:0]            src,
   input  logic [NUM_EVT-1:0][VEC_W-1:0] vec,
   input  logic                          clr_we,
   input  logic [VEC_W-1:0]              clr_vec,
   output logic [NUM_PEND-1:0]           set_vec,
   output logic [NUM_PEND-1:0]           pend
);
   always_comb begin
      set_vec = '0;
      for (int e = 0; e < NUM_EVT; e++) begin
         if (src[e]) set_vec[vec[e]] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~(clr_we ? (NUM_PEND'(1) << clr_vec) : '0)) | set_vec;
   end
endmodule

// File: rtl/evt_irq_ctl.sv
module evt_irq_ctl
   import evt_irq_pkg::*;
#(
   parameter int unsigned NUM_CHIP  = 32,
   parameter int unsigned NUM_QUEUE = 32,
   parameter int unsigned VEC_W     = 5,
   localparam int unsigned NUM_EVT  = NUM_CHIP + NUM_QUEUE,
   localparam int unsigned IDX_W    = $clog2(NUM_EVT),
   localparam int unsigned NUM_PEND = 1 << VEC_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   input  logic                 reg_secure,
   output logic [DATA_W-1:0]    reg_rdata,
   input  logic [NUM_CHIP-1:0]  chip_evt,
   input  logic [NUM_QUEUE-1:0] q_nonempty,
   output logic                 pkt_valid,
   input  logic                 pkt_ready,
   output logic [IDX_W-1:0]     pkt_evt,
   output logic [MPS_W-1:0]     pkt_mps,
   output logic [VEC_W-1:0]     pkt_vec,
   output logic [NUM_PEND-1:0]  irq_pend
);
   if (NUM_PEND > DATA_W) begin : g_chk_pend
      $error("pending bits do not fit one register");
   end
   if (NUM_EVT > DATA_W * 2) begin : g_chk_evt
      $error("event count above supported range");
   end

   reg_sel_e                    rsel;
   logic                        mode_local;
   logic [IDX_W-1:0]            idx;
   logic [DATA_W-1:0]           val_word;
   logic [NUM_EVT-1:0]          en, swen, pol, sec, sw_hit, raise, drain, pend_src;
   logic [NUM_EVT-1:0][MPS_W-1:0] mps;
   logic [NUM_EVT-1:0][VEC_W-1:0] vec;
   logic [NUM_PEND-1:0]         pend_set_vec;
   logic [IDX_W-1:0]            sw_idx;
   logic                        sw_ok;

   assign rsel = reg_sel_e'(reg_addr[ADDR_W-1:2]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mode_local <= 1'b0;
      else if (reg_we && rsel == RS_MODE)  mode_local <= reg_wdata[0];
   end

   evt_cfg_bank #(.NUM_EVT(NUM_EVT), .VEC_W(VEC_W)) u_cfg (
      .clk, .rst_n,
      .wr_idx   (reg_we && rsel == RS_IDX),
      .wr_val   (reg_we && rsel == RS_VAL),
      .wdata    (reg_wdata),
      .idx, .val_word, .en, .swen, .pol, .sec, .mps, .vec
   );

   // software trigger qualification
   assign sw_idx = reg_wdata[IDX_W-1:0];
   assign sw_ok  = reg_we && rsel == RS_SWI && en[sw_idx] && swen[sw_idx]
                   && (!sec[sw_idx] || reg_secure);
   assign sw_hit = sw_ok ? (NUM_EVT'(1) << sw_idx) : '0;

   evt_detect #(.NUM_EVT(NUM_EVT)) u_det (
      .clk, .rst_n,
      .lvl_in ({q_nonempty, chip_evt}),
      .en, .pol, .sw_hit, .raise
   );

   evt_pkt_arb #(.NUM_EVT(NUM_EVT)) u_arb (
      .clk, .rst_n,
      .remote (!mode_local),
      .raise,
      .ready  (pkt_ready),
      .valid  (pkt_valid),
      .sel    (pkt_evt),
      .drain
   );

   assign pkt_mps  = mps[pkt_evt];
   assign pkt_vec  = vec[pkt_evt];
   assign pend_src = (mode_local ? raise : '0) | drain;

   evt_pend #(.NUM_EVT(NUM_EVT), .VEC_W(VEC_W)) u_pend (
      .clk, .rst_n,
      .src     (pend_src),
      .vec,
      .clr_we  (reg_we && rsel == RS_CLR),
      .clr_vec (reg_wdata[VEC_W-1:0]),
      .set_vec (pend_set_vec),
      .pend    (irq_pend)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (rsel)
         RS_IDX:  reg_rdata[IDX_W-1:0]    = idx;
         RS_VAL:  reg_rdata               = val_word;
         RS_PEND: reg_rdata[NUM_PEND-1:0] = irq_pend;
         RS_MODE: reg_rdata[0]            = mode_local;
         default: reg_rdata               = '0;
      endcase
   end
endmodule

// File: rtl/evt_irq_ctl_chk.sv
module evt_irq_ctl_chk
   import evt_irq_pkg::*;
#(
   parameter int unsigned IDX_W = 6,
   parameter int unsigned VEC_W = 5
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   reg_we,
   input logic [ADDR_W-1:0]      reg_addr,
   input logic [DATA_W-1:0]      reg_wdata,
   input logic [DATA_W-1:0]      reg_rdata,
   input logic                   mode_local,
   input logic                   pkt_valid,
   input logic                   pkt_ready,
   input logic [IDX_W-1:0]       pkt_evt,
   input logic [(1<<VEC_W)-1:0]  pend_set,
   input logic [(1<<VEC_W)-1:0]  irq_pend
);
   logic [2:0] sel;
   assign sel = reg_addr[ADDR_W-1:2];

   AST_TYPE_MPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      sel == 3'd1 |-> (reg_rdata[F_TYPE] == 1'b0 && reg_rdata[15:11] == 5'd0)); // R3

   AST_PKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && !pkt_ready && !(reg_we && sel == 3'd5))
      |=> (pkt_valid && $stable(pkt_evt))); // R7

   AST_LOCAL_NO_PKT: assert property (@(posedge clk) disable iff (!rst_n)
      mode_local |=> !pkt_valid); // R6

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && sel == 3'd3 && !pend_set[reg_wdata[VEC_W-1:0]])
      |=> !irq_pend[$past(reg_wdata[VEC_W-1:0])]); // R11
endmodule

bind evt_irq_ctl evt_irq_ctl_chk #(.IDX_W(IDX_W), .VEC_W(VEC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_we     (reg_we),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .mode_local (mode_local),
   .pkt_valid  (pkt_valid),
   .pkt_ready  (pkt_ready),
   .pkt_evt    (pkt_evt),
   .pend_set   (pend_set_vec),
   .irq_pend   (irq_pend)
);

// File: tb/evt_irq_ctl_tb.sv
module evt_irq_ctl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        reg_secure = 1'b0;
   logic [31:0] reg_rdata;
   logic [31:0] chip_evt = '0;
   logic [31:0] q_nonempty = '0;
   logic        pkt_valid;
   logic        pkt_ready = 1'b0;
   logic [5:0]  pkt_evt;
   logic [2:0]  pkt_mps;
   logic [4:0]  pkt_vec;
   logic [31:0] irq_pend;
   int n_chk = 0;
   int n_bad = 0;

   localparam logic [4:0] A_IDX = 5'h00, A_VAL = 5'h04, A_SWI = 5'h08,
                          A_CLR = 5'h0C, A_PEND = 5'h10, A_MODE = 5'h14;

   always #2 clk = ~clk;

   evt_irq_ctl u_dut (.*);

   function automatic logic [31:0] cw(bit en, bit swen, bit sec, bit pol,
                                      logic [2:0] mps, logic [4:0] vec);
      return (32'(en) << 20) | (32'(swen) << 19) | (32'(sec) << 18) |
             (32'(pol) << 17) | (32'(mps) << 8) | 32'(vec);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d, bit s = 1'b0);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_secure = s;
      @(negedge clk);
      reg_we = 1'b0; reg_secure = 1'b0;
   endtask

   task automatic rd(logic [4:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic cfg(int e, logic [31:0] w);
      wr(A_IDX, 32'(e));
      wr(A_VAL, w);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 pend", irq_pend, 0);
      chk("R1 valid", 32'(pkt_valid), 0);
      rd(A_VAL, d);  chk("R1 value", d, 0);
      rd(A_IDX, d);  chk("R1 index", d, 0);
      rd(A_MODE, d); chk("R1 mode", d, 0);
   endtask

   task automatic t_window;
      logic [31:0] d;
      cfg(5, cw(0, 1, 1, 1, 3'd5, 5'd13) | 32'h0001_7800);
      rd(A_VAL, d); chk("R2 R3 value fields", d, cw(0, 1, 1, 1, 3'd5, 5'd13));
      rd(A_IDX, d); chk("R2 index readback", d, 5);
      wr(A_IDX, 6);
      rd(A_VAL, d); chk("R2 other entry untouched", d, 0);
      wr(A_IDX, 5);
      rd(A_VAL, d); chk("R2 entry kept", d, cw(0, 1, 1, 1, 3'd5, 5'd13));
   endtask

   task automatic t_chip;
      logic [31:0] d;
      cfg(2, cw(1, 0, 0, 0, 0, 5'd3));
      @(negedge clk); chip_evt[2] = 1'b1;
      @(negedge clk);
      chk("R4 R6 chip pol0 sets pend", irq_pend, 32'h8);
      wr(A_CLR, 3);
      chk("R11 clear", irq_pend, 0);
      chip_evt[4] = 1'b1;
      cfg(4, cw(1, 0, 0, 1, 0, 5'd4));
      @(negedge clk); @(negedge clk);
      chk("R4 pol1 idle while high", irq_pend, 0);
      chip_evt[4] = 1'b0;
      @(negedge clk);
      chk("R4 pol1 fires on low", irq_pend, 32'h10);
      chip_evt[9] = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R4 disabled ignored", irq_pend, 32'h10);
      wr(A_CLR, 4);
      rd(A_PEND, d); chk("R2 R11 pend reg", d, 0);
   endtask

   task automatic t_queue;
      cfg(35, cw(1, 0, 0, 0, 0, 5'd7));
      @(negedge clk);
      chk("R5 empty queue pol0 quiet", irq_pend, 0);
      q_nonempty[3] = 1'b1;
      @(negedge clk);
      chk("R5 nonempty pol0 fires", irq_pend, 32'h80);
      cfg(36, cw(1, 0, 0, 1, 0, 5'd8));
      @(negedge clk);
      chk("R5 empty pol1 fires", irq_pend, 32'h180);
      wr(A_CLR, 7); wr(A_CLR, 8);
      chk("R11 both cleared", irq_pend, 0);
   endtask

   task automatic t_sw;
      cfg(10, cw(1, 1, 0, 0, 0, 5'd10));
      wr(A_SWI, 10);
      chk("R9 sw accepted", irq_pend, 32'h400);
      cfg(11, cw(1, 0, 0, 0, 0, 5'd11));
      wr(A_SWI, 11);
      chk("R9 sw no swen ignored", irq_pend, 32'h400);
      cfg(12, cw(0, 1, 0, 0, 0, 5'd12));
      wr(A_SWI, 12);
      chk("R9 sw no enable ignored", irq_pend, 32'h400);
      wr(A_CLR, 10);
   endtask

   task automatic t_secure;
      cfg(13, cw(1, 1, 1, 0, 0, 5'd14));
      wr(A_SWI, 13, 1'b0);
      chk("R10 nonsecure ignored", irq_pend, 0);
      wr(A_SWI, 13, 1'b1);
      chk("R10 secure accepted", irq_pend, 32'h4000);
      wr(A_CLR, 14);
   endtask

   task automatic t_remote;
      wr(A_MODE, 0);
      cfg(20, cw(1, 1, 0, 0, 3'd6, 5'd21));
      wr(A_SWI, 20);
      chk("R7 valid", 32'(pkt_valid), 1);
      chk("R7 fields", {pkt_evt, pkt_mps, pkt_vec}, {6'd20, 3'd6, 5'd21});
      repeat (3) @(negedge clk);
      chk("R7 held", {pkt_valid, pkt_evt}, {1'b1, 6'd20});
      chk("R7 no pending", irq_pend, 0);
      pkt_ready = 1'b1; @(negedge clk); pkt_ready = 1'b0;
      chk("R7 accepted", 32'(pkt_valid), 0);
   endtask

   task automatic t_order;
      cfg(24, cw(1, 0, 0, 0, 3'd1, 5'd1));
      cfg(27, cw(1, 0, 0, 0, 3'd2, 5'd2));
      chip_evt[24] = 1'b1; chip_evt[27] = 1'b1;
      @(negedge clk);
      chk("R8 lowest first", {pkt_valid, pkt_evt}, {1'b1, 6'd24});
      pkt_ready = 1'b1; @(negedge clk); pkt_ready = 1'b0;
      chk("R8 next", {pkt_valid, pkt_evt, pkt_mps}, {1'b1, 6'd27, 3'd2});
      pkt_ready = 1'b1; @(negedge clk); pkt_ready = 1'b0;
      chk("R8 drained", 32'(pkt_valid), 0);
      chip_evt[24] = 1'b0; chip_evt[27] = 1'b0;
      @(negedge clk);
      chip_evt[27] = 1'b1; @(negedge clk);
      chip_evt[24] = 1'b1; @(negedge clk);
      chk("R7 presented request held", {pkt_valid, pkt_evt}, {1'b1, 6'd27});
      pkt_ready = 1'b1; @(negedge clk); pkt_ready = 1'b0;
      chk("R8 then lower", {pkt_valid, pkt_evt}, {1'b1, 6'd24});
      pkt_ready = 1'b1; @(negedge clk); pkt_ready = 1'b0;
   endtask

   task automatic t_drain;
      wr(A_SWI, 20);
      chk("R12 request waiting", 32'(pkt_valid), 1);
      wr(A_MODE, 1);
      chk("R12 valid drops", 32'(pkt_valid), 0);
      @(negedge clk);
      chk("R12 drained to pend", irq_pend, 32'h0020_0000);
   endtask

   initial begin
      #(4 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_window();
      wr(A_MODE, 1);
      t_chip();
      t_queue();
      t_sw();
      t_secure();
      t_remote();
      t_order();
      t_drain();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule